// File: doc/BRIEF.md
# DMA Interrupt Status and Enable Register

This block gathers the interrupt causes of a ten-channel DMA engine into one 32-bit register and drives a single interrupt line toward the processor. Each channel raises a one-cycle completion pulse, and the engine raises separate pulses for a stall, an empty memory FIFO and a bus error. Each pulse latches a sticky status bit. Next to the status bits sit enable bits, one per channel and one each for the stall and FIFO-empty causes. The bus-error cause has no enable and always interrupts.

Software uses one register word through a plain select / write-enable port. A one written into a status position clears that bit. A one written into an enable position flips that bit. A zero written anywhere changes nothing. Because of this, software can acknowledge causes and adjust enables without a read-modify-write sequence. The interrupt line is registered and follows the enabled status one cycle later.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After a synchronous reset every register bit reads 0 and `irq` is 0.
- R2: A pulse on `ch_done[n]` sets status bit n (bits 9:0). The bit stays set until software clears it.
- R3: A pulse on `stall_evt` sets bit 13, a pulse on `fifo_empty_evt` sets bit 14, and a pulse on `bus_err_evt` sets bit 15. Each of these bits is sticky.
- R4: A write with a one in any of bits 9:0 or 15:13 clears that status bit. Status bits whose write-data position is zero keep their value.
- R5: A write with a one in any of bits 25:16 (channel n enable at 16+n), bit 29 (stall enable) or bit 30 (FIFO-empty enable) inverts that enable bit. Enable bits whose write-data position is zero keep their value.
- R6: If a hardware set pulse and a software clear hit the same status bit in one cycle, the bit ends up set.
- R7: `irq` is 1 exactly one cycle after some status bit is set while its enable is set. The bus-error status counts as always enabled.
- R8: Bits 31, 28:26 and 12:10 always read 0. Writes to these bit positions change nothing.
- R9: A write takes effect only in a cycle where `sel` and `wr_en` are both 1. `rdata` is 0 whenever `sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register select for read and write |
| wr_en | input | 1 | Write strobe, valid with `sel` |
| wdata | input | 32 | Write data (ones clear status bits or flip enable bits) |
| rdata | output | 32 | Register image while `sel` is 1, otherwise 0 |
| ch_done | input | 10 | Per-channel completion pulses |
| stall_evt | input | 1 | Stall event pulse |
| fifo_empty_evt | input | 1 | Memory-FIFO-empty event pulse |
| bus_err_evt | input | 1 | Bus-error event pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
A hardware set pulse and a software write-one-to-clear can land on the same status bit in the same cycle. The bench provokes this by driving `stall_evt` in the same cycle as a write that clears bits 13 and 14. It then expects bit 13 to remain set, because set takes priority, and bit 14 to be cleared, because nothing set it. A second collision, in which a status bit rises while its enable is already set, is judged on `irq`: the line must still be low in the cycle the status bit becomes visible and must be high one cycle later.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    localparam int NUM_CH   = 10;
    localparam int NUM_GLB  = 3;   // stall, fifo-empty, bus-error
    localparam int STAT_W   = NUM_CH + NUM_GLB;
    localparam int EN_W     = NUM_CH + NUM_GLB - 1;  // bus error has no enable
    localparam int WORD_W   = 32;

    localparam logic [WORD_W-1:0] USED_MASK = 32'h63FF_E3FF;

    // Register image, msb first; field positions are software visible.
    typedef struct packed {
        logic              rsvd_31;
        logic              fifo_en;     // 30
        logic              stall_en;    // 29
        logic [2:0]        rsvd_28_26;
        logic [NUM_CH-1:0] ch_en;       // 25:16
        logic              berr_st;     // 15
        logic              fifo_st;     // 14
        logic              stall_st;    // 13
        logic [2:0]        rsvd_12_10;
        logic [NUM_CH-1:0] ch_st;       // 9:0
    } dirq_word_t;

    // status vector order: {berr, fifo, stall, ch}
    function automatic logic [STAT_W-1:0] stat_of(dirq_word_t w);
        return {w.berr_st, w.fifo_st, w.stall_st, w.ch_st};
    endfunction

    // enable vector order: {fifo, stall, ch}
    function automatic logic [EN_W-1:0] en_of(dirq_word_t w);
        return {w.fifo_en, w.stall_en, w.ch_en};
    endfunction

    function automatic dirq_word_t build_word(logic [STAT_W-1:0] st, logic [EN_W-1:0] en);
        dirq_word_t w;
        w            = '0;
        w.ch_st      = st[NUM_CH-1:0];
        w.stall_st   = st[NUM_CH];
        w.fifo_st    = st[NUM_CH+1];
        w.berr_st    = st[NUM_CH+2];
        w.ch_en      = en[NUM_CH-1:0];
        w.stall_en   = en[NUM_CH];
        w.fifo_en    = en[NUM_CH+1];
        return w;
    endfunction

endpackage

// File: rtl/dirq_w1c_bank.sv
module dirq_w1c_bank #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_r[i] <= 1'b0;
            else if (set_i[i])
                q_r[i] <= 1'b1;        // set has priority over clear
            else if (clr_i[i])
                q_r[i] <= 1'b0;
        end
    end

    assign q_o = q_r;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((q_r & $past(set_i)) == $past(set_i)));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & ~set_i) != '0) |=> ((q_r & $past(clr_i & ~set_i)) == '0));

    // R2
    stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((set_i | clr_i) == '0) |=> $stable(q_r));

endmodule

// File: rtl/dirq_toggle_bank.sv
module dirq_toggle_bank #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tgl_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else
            q_r <= q_r ^ tgl_i;
    end

    assign q_o = q_r;

    // R5
    tgl_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (tgl_i != '0) |=> ((q_r ^ $past(q_r)) == $past(tgl_i)));

    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tgl_i == '0) |=> $stable(q_r));

endmodule

// File: rtl/dirq_combine.sv
module dirq_combine #(
    parameter int SW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] stat_i,
    input  logic [SW-2:0] en_i,
    output logic          irq_o
);
    localparam int EW = SW - 1;

    logic [SW-1:0] en_full;
    logic          irq_q;

    // top status bit (bus error) is permanently enabled
    assign en_full = {1'b1, en_i[EW-1:0]};

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |(stat_i & en_full);
    end

    assign irq_o = irq_q;

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat_i & en_full) == '0) |=> !irq_o);

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_i[SW-1]) |=> irq_o);

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic              stall_evt,
    input  logic              fifo_empty_evt,
    input  logic              bus_err_evt,
    output logic              irq
);
    dirq_word_t     wr_word;
    dirq_word_t     img;
    logic           wr_fire;
    logic [STAT_W-1:0] st_set, st_clr, st_q;
    logic [EN_W-1:0]   en_tgl, en_q;

    assign wr_word = dirq_word_t'(wdata);
    assign wr_fire = sel & wr_en;

    assign st_set = {bus_err_evt, fifo_empty_evt, stall_evt, ch_done};
    assign st_clr = wr_fire ? stat_of(wr_word) : '0;
    assign en_tgl = wr_fire ? en_of(wr_word)   : '0;

    dirq_w1c_bank #(.W(STAT_W)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .set_i (st_set),
        .clr_i (st_clr),
        .q_o   (st_q)
    );

    dirq_toggle_bank #(.W(EN_W)) u_en (
        .clk   (clk),
        .rst   (rst),
        .tgl_i (en_tgl),
        .q_o   (en_q)
    );

    dirq_combine #(.SW(STAT_W)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .stat_i (st_q),
        .en_i   (en_q),
        .irq_o  (irq)
    );

    assign img   = build_word(st_q, en_q);
    assign rdata = sel ? WORD_W'(img) : '0;

    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((rdata & ~USED_MASK) == '0));

    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel) |-> (rdata == '0));

    // R9
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_fire && st_set == '0) |=> ($stable(st_q) && $stable(en_q)));

endmodule

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        sel, wr_en;
    logic [31:0] wdata, rdata;
    logic [9:0]  ch_done;
    logic        stall_evt, fifo_empty_evt, bus_err_evt;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma_irq_ctrl u_dma_irq_ctrl (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .ch_done(ch_done), .stall_evt(stall_evt),
        .fifo_empty_evt(fifo_empty_evt), .bus_err_evt(bus_err_evt), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, applied at a falling edge, removed at the next
    task automatic cyc(input logic s, input logic w, input logic [31:0] d,
                       input logic [9:0] ch, input logic st, input logic fe, input logic be);
        @(negedge clk);
        sel = s; wr_en = w; wdata = d;
        ch_done = ch; stall_evt = st; fifo_empty_evt = fe; bus_err_evt = be;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; wdata = '0;
        ch_done = '0; stall_evt = 1'b0; fifo_empty_evt = 1'b0; bus_err_evt = 1'b0;
    endtask

    task automatic wr(input logic [31:0] d);
        cyc(1'b1, 1'b1, d, '0, 1'b0, 1'b0, 1'b0);
    endtask

    // waits one falling edge, then reads with sel high (no edge in between)
    task automatic rd(output logic [31:0] v);
        @(negedge clk);
        sel = 1'b1;
        #1 v = rdata;
        sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst = 1'b1; sel = 0; wr_en = 0; wdata = '0; ch_done = '0;
        stall_evt = 0; fifo_empty_evt = 0; bus_err_evt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(v);
        chk("R1 reset image", v, 32'h0);
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_channels();
        logic [31:0] v;
        cyc(1'b0, 1'b0, '0, 10'h208, 1'b0, 1'b0, 1'b0);
        rd(v);
        chk("R2 ch3/ch9 set", v, 32'h0000_0208);
        rd(v);
        chk("R2 sticky", v, 32'h0000_0208);
        chk("R7 masked channels no irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_globals();
        logic [31:0] v;
        cyc(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 1'b1);
        chk("R7 bus error latency", {31'b0, irq}, 32'h0);
        rd(v);
        chk("R3 global status bits", v, 32'h0000_E208);
        chk("R7 bus error always enabled", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(32'h0000_8208);
        rd(v);
        chk("R4 w1c partial clear", v, 32'h0000_6000);
        chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_toggle();
        logic [31:0] v;
        wr(32'h2000_0000);
        chk("R7 enable latency", {31'b0, irq}, 32'h0);
        rd(v);
        chk("R5 stall enable flipped on", v, 32'h2000_6000);
        chk("R7 stall enabled irq", {31'b0, irq}, 32'h1);
        wr(32'h2000_0000);
        rd(v);
        chk("R5 stall enable flipped off", v, 32'h0000_6000);
        chk("R7 irq after disable", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        cyc(1'b1, 1'b1, 32'h0000_6000, '0, 1'b1, 1'b0, 1'b0);
        rd(v);
        chk("R6 set beats clear", v, 32'h0000_2000);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(32'h9C00_1C00);
        rd(v);
        chk("R8 reserved write ignored", v, 32'h0000_2000);
    endtask

    task automatic t_select();
        logic [31:0] v;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b1; wdata = 32'h2000_2000;
        #1 chk("R9 rdata zero when unselected", rdata, 32'h0);
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        rd(v);
        chk("R9 write without sel ignored", v, 32'h0000_2000);
    endtask

    task automatic t_chan_irq();
        logic [31:0] v;
        wr(32'h0020_2000);
        rd(v);
        chk("R5 ch5 enable and R4 clear", v, 32'h0020_0000);
        cyc(1'b0, 1'b0, '0, 10'h020, 1'b0, 1'b0, 1'b0);
        chk("R7 ch5 irq latency", {31'b0, irq}, 32'h0);
        rd(v);
        chk("R2 ch5 status", v, 32'h0020_0020);
        chk("R7 ch5 irq high", {31'b0, irq}, 32'h1);
        wr(32'h0000_0020);
        chk("R7 irq held until next cycle", {31'b0, irq}, 32'h1);
        rd(v);
        chk("R4 ch5 cleared", v, 32'h0020_0000);
        chk("R7 ch5 irq low", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        #500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_channels();
        t_globals();
        t_clear();
        t_toggle();
        t_collide();
        t_reserved();
        t_select();
        t_chan_irq();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule